// File: doc/BRIEF.md
# Four-Bank Register-Mapped GPIO Port Block

This block gives software control over 128 general-purpose pins, arranged as four banks of 32, through a simple 32-bit register bus with single-cycle read and write strobes. Every bank owns a drive-data register and a direction register. A set direction bit turns the pin into an output: the block asserts its output enable and drives the stored data bit. A clear direction bit leaves the pin as an input, and the block samples the pad level through a two-flop synchronizer.

For each bank, software can also read a merged value. Output pins contribute their driven bits and input pins contribute their synchronized pad levels. Accesses to the interrupt register window of bank A are not served locally. They are handed to a companion interrupt unit through a forwarding port, and read data from that port is returned on the bus. An access to an offset that nothing decodes reads as zero and changes nothing. It also sets a sticky error flag that only reset clears.

Top module: `gpio_ports`

## Requirements
- R1: After reset every data and direction register is zero, so `padOut`, `padOe`, `busErr` and `busRdata` are all zero.
- R2: The bank b data register sits at byte offset 12*b and its direction register at 12*b+4, for b = 0..3. A write updates the register at the clock edge, and a read returns the register.
- R3: Pin 32*b+i drives `padOut` with data bit i of bank b. `padOe` for that pin equals direction bit i, where 1 means output and 0 means input.
- R4: A read of offset 0x50+4*b returns (data AND dir) OR (syncIn AND NOT dir) for bank b, where syncIn is the synchronized `padIn` slice [32*b+31:32*b].
- R5: Writes to the merged-value offsets 0x50..0x5c are ignored. No data or direction register, `padOut` or `padOe` changes.
- R6: `padIn` passes through two flops. A read at clock edge k returns pad levels sampled at edge k-2, so a change applied just before edge j shows in reads captured at edge j+2 or later.
- R7: Offset 0x64 (identifier) always reads zero. Offset 0x4c (interrupt acknowledge) reads zero but is forwarded to the interrupt unit.
- R8: An access to offsets 0x30..0x4c raises `irqAccess` in the same cycle. `irqWrite` copies the bus write flag and `irqAddr`/`irqWdata` copy the bus. A read of 0x30..0x48 returns `irqRdata`.
- R9: Any access to an offset not listed in R2, R4, R7 or R8 is unmapped, including an offset whose two low bits are nonzero. It reads zero, writes have no effect, and it sets `busErr`, which stays set until reset. Mapped accesses never set `busErr`.
- R10: `busRdata` is registered. It shows the read result in the cycle after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 8 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | Sticky unmapped-access flag |
| padIn | input | 128 | External pin levels |
| padOut | output | 128 | Pin drive data |
| padOe | output | 128 | Pin output enables |
| irqAccess | output | 1 | Forwarded interrupt-window access strobe |
| irqWrite | output | 1 | Forwarded write flag |
| irqAddr | output | 8 | Forwarded offset |
| irqWdata | output | 32 | Forwarded write data |
| irqRdata | input | 32 | Read data from the interrupt unit |

## Verification
The hardest case to reach is the two-cycle window of R6, where the pad has changed but a merged-value read must still return the old level. The bench reaches it by changing `padIn` on a falling edge and issuing back-to-back reads from that same edge: it expects the old value twice and the new value on the third read. A full sweep of every word offset runs after the data and direction registers are loaded with distinct patterns and the pads carry mixed levels. Because of this, a decode that aliases one offset onto another returns a value that differs from the bench's model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int MaxBanks = 4;
  localparam int BankIdxW = $clog2(MaxBanks);

  typedef enum logic [2:0] {
    RdZero = 3'd0,
    RdData = 3'd1,
    RdDir  = 3'd2,
    RdEff  = 3'd3,
    RdIrq  = 3'd4
  } rdKind_t;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic                wrData;
    logic                wrDir;
    logic [BankIdxW-1:0] bank;
    rdKind_t             rdKind;
    logic                rdStrobe;
  } ctlStrobes_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int Width  = 128,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] d,
  output logic [Width-1:0] q
);

  logic [Stages-1:0][Width-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < Stages; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[Stages-1];

endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
  import gpio_pkg::*;
#(
  parameter int NumBanks   = 4,
  parameter int AddrW      = 8,
  parameter int BankStride = 12,
  parameter int IrqLo      = 'h30,
  parameter int IrqHi      = 'h48,
  parameter int AckOfs     = 'h4c,
  parameter int EffBase    = 'h50,
  parameter int IdOfs      = 'h64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [AddrW-1:0] busAddr,
  output ctlStrobes_t      ctl,
  output logic             irqFwd,
  output logic             errFlag
);

  logic hit;
  logic isData;
  logic isDir;
  logic fwd;
  logic badAccess;

  always_comb begin
    hit        = 1'b0;
    isData     = 1'b0;
    isDir      = 1'b0;
    fwd        = 1'b0;
    ctl        = '0;
    ctl.rdKind = RdZero;
    if (busAddr[1:0] == 2'b00) begin
      for (int b = 0; b < NumBanks; b++) begin
        if (busAddr == AddrW'(b * BankStride)) begin
          hit        = 1'b1;
          isData     = 1'b1;
          ctl.bank   = BankIdxW'(b);
          ctl.rdKind = RdData;
        end
        if (busAddr == AddrW'(b * BankStride + 4)) begin
          hit        = 1'b1;
          isDir      = 1'b1;
          ctl.bank   = BankIdxW'(b);
          ctl.rdKind = RdDir;
        end
        if (busAddr == AddrW'(EffBase + 4 * b)) begin
          hit        = 1'b1;
          ctl.bank   = BankIdxW'(b);
          ctl.rdKind = RdEff;
        end
      end
      if (busAddr >= AddrW'(IrqLo) && busAddr <= AddrW'(IrqHi)) begin
        hit        = 1'b1;
        fwd        = 1'b1;
        ctl.rdKind = RdIrq;
      end
      if (busAddr == AddrW'(AckOfs)) begin
        hit = 1'b1;
        fwd = 1'b1;
      end
      if (busAddr == AddrW'(IdOfs)) begin
        hit = 1'b1;
      end
    end
    ctl.wrData   = busSel & busWrite & isData;
    ctl.wrDir    = busSel & busWrite & isDir;
    ctl.rdStrobe = busSel & ~busWrite;
    badAccess    = busSel & ~hit;
  end

  assign irqFwd = busSel & fwd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (badAccess) begin
      errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int NumBanks   = 4,
  parameter int DataW      = 32,
  parameter int SyncStages = 2,
  localparam int PinCount  = NumBanks * DataW
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         ctl,
  input  logic [DataW-1:0]    busWdata,
  input  logic [DataW-1:0]    irqRdata,
  input  logic [PinCount-1:0] padIn,
  output logic [PinCount-1:0] padOut,
  output logic [PinCount-1:0] padOe,
  output logic [DataW-1:0]    busRdata
);

  logic [NumBanks-1:0][DataW-1:0] dataAll;
  logic [NumBanks-1:0][DataW-1:0] dirAll;
  logic [NumBanks-1:0][DataW-1:0] syncAll;
  logic [NumBanks-1:0][DataW-1:0] effAll;
  logic [PinCount-1:0]            syncFlat;

  gpio_sync #(
    .Width (PinCount),
    .Stages(SyncStages)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (padIn),
    .q   (syncFlat)
  );

  assign syncAll = syncFlat;

  for (genvar b = 0; b < NumBanks; b++) begin : g_bank
    logic [DataW-1:0] dataReg;
    logic [DataW-1:0] dirReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataReg <= '0;
        dirReg  <= '0;
      end else begin
        if (ctl.wrData && ctl.bank == BankIdxW'(b)) dataReg <= busWdata;
        if (ctl.wrDir && ctl.bank == BankIdxW'(b))  dirReg  <= busWdata;
      end
    end

    assign dataAll[b] = dataReg;
    assign dirAll[b]  = dirReg;
    assign effAll[b]  = (dataReg & dirReg) | (syncAll[b] & ~dirReg);
  end

  assign padOut = dataAll;
  assign padOe  = dirAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (ctl.rdStrobe) begin
      case (ctl.rdKind)
        RdData:  busRdata <= dataAll[ctl.bank];
        RdDir:   busRdata <= dirAll[ctl.bank];
        RdEff:   busRdata <= effAll[ctl.bank];
        RdIrq:   busRdata <= irqRdata;
        default: busRdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_ports.sv
module gpio_ports
  import gpio_pkg::*;
#(
  parameter int NumBanks   = 4,
  parameter int DataW      = 32,
  parameter int AddrW      = 8,
  parameter int SyncStages = 2,
  localparam int PinCount  = NumBanks * DataW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [AddrW-1:0]    busAddr,
  input  logic [DataW-1:0]    busWdata,
  output logic [DataW-1:0]    busRdata,
  output logic                busErr,
  input  logic [PinCount-1:0] padIn,
  output logic [PinCount-1:0] padOut,
  output logic [PinCount-1:0] padOe,
  output logic                irqAccess,
  output logic                irqWrite,
  output logic [AddrW-1:0]    irqAddr,
  output logic [DataW-1:0]    irqWdata,
  input  logic [DataW-1:0]    irqRdata
);

  ctlStrobes_t ctl;
  logic        irqFwd;

  gpio_ctl #(
    .NumBanks(NumBanks),
    .AddrW   (AddrW)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .ctl     (ctl),
    .irqFwd  (irqFwd),
    .errFlag (busErr)
  );

  gpio_dp #(
    .NumBanks  (NumBanks),
    .DataW     (DataW),
    .SyncStages(SyncStages)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .busWdata(busWdata),
    .irqRdata(irqRdata),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .busRdata(busRdata)
  );

  assign irqAccess = irqFwd;
  assign irqWrite  = irqFwd & busWrite;
  assign irqAddr   = busAddr;
  assign irqWdata  = busWdata;

endmodule

// File: rtl/gpio_ports_chk.sv
module gpio_ports_chk #(
  parameter int NumBanks  = 4,
  parameter int DataW     = 32,
  parameter int AddrW     = 8,
  localparam int PinCount = NumBanks * DataW
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [AddrW-1:0]    busAddr,
  input logic [DataW-1:0]    busRdata,
  input logic                busErr,
  input logic [PinCount-1:0] padIn,
  input logic [PinCount-1:0] padOut,
  input logic [PinCount-1:0] padOe,
  input logic                irqAccess
);

  logic [2:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R2
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite) |=> ($stable(padOut) && $stable(padOe)));

  // R5
  eff_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr >= AddrW'('h50) && busAddr <= AddrW'('h5c))
      |=> ($stable(padOut) && $stable(padOe)));

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd4 && busSel && !busWrite && busAddr == AddrW'('h50))
      |=> (busRdata == (($past(padOut[DataW-1:0]) & $past(padOe[DataW-1:0]))
                      | ($past(padIn[DataW-1:0], 3) & ~$past(padOe[DataW-1:0])))));

  // R7
  id_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busAddr == AddrW'('h64)) |=> (busRdata == '0));

  // R8
  irq_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAccess |-> (busSel && busAddr >= AddrW'('h30) && busAddr <= AddrW'('h4c)
                   && busAddr[1:0] == 2'b00));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> busErr);

  // R9
  unmapped_sets_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr == AddrW'('h08)) |=> busErr);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd1 && !(busSel && !busWrite)) |=> $stable(busRdata));

endmodule

bind gpio_ports gpio_ports_chk #(
  .NumBanks(NumBanks),
  .DataW   (DataW),
  .AddrW   (AddrW)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .busErr   (busErr),
  .padIn    (padIn),
  .padOut   (padOut),
  .padOe    (padOe),
  .irqAccess(irqAccess)
);

// File: tb/sim_gpio_ports.sv
`timescale 1ns/1ps
module sim_gpio_ports;

  localparam int NB = 4;
  localparam int DW = 32;
  localparam int PC = NB * DW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          busErr;
  logic [PC-1:0] padIn = '0;
  logic [PC-1:0] padOut;
  logic [PC-1:0] padOe;
  logic          irqAccess;
  logic          irqWrite;
  logic [7:0]    irqAddr;
  logic [DW-1:0] irqWdata;
  logic [DW-1:0] irqRdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] mData [NB];
  logic [DW-1:0] mDir  [NB];

  always #4 clk = ~clk;

  assign irqRdata = irqAccess ? {24'hC3C3C3, irqAddr} : '0;

  gpio_ports u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .irqAccess(irqAccess), .irqWrite(irqWrite), .irqAddr(irqAddr),
    .irqWdata(irqWdata), .irqRdata(irqRdata)
  );

  task automatic chk(input string req, input logic [PC-1:0] got, input logic [PC-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [DW-1:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [DW-1:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    d = busRdata;
    busSel = 1'b0;
  endtask

  function automatic logic [DW-1:0] effOf(input int b);
    return (mData[b] & mDir[b]) | (padIn[b*DW +: DW] & ~mDir[b]);
  endfunction

  function automatic logic [DW-1:0] expRead(input int a);
    for (int b = 0; b < NB; b++) begin
      if (a == 12*b)       return mData[b];
      if (a == 12*b + 4)   return mDir[b];
      if (a == 'h50 + 4*b) return effOf(b);
    end
    if (a >= 'h30 && a <= 'h48) return {24'hC3C3C3, 8'(a)};
    return '0;
  endfunction

  function automatic bit isMapped(input int a);
    if (a % 4 != 0) return 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (a == 12*b || a == 12*b + 4 || a == 'h50 + 4*b) return 1'b1;
    end
    return (a >= 'h30 && a <= 'h4c) || a == 'h64;
  endfunction

  function automatic logic [DW-1:0] pat(input int b, input int k);
    return (32'h9E37_79B9 * (k + 1)) ^ (32'(b) << 12) ^ 32'(k * 7);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] rd;
    logic [DW-1:0] r1, r2, r3;
    logic [PC-1:0] oldPad;
    for (int b = 0; b < NB; b++) begin mData[b] = '0; mDir[b] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 padOut", padOut, '0);
    chk("R1 padOe", padOe, '0);
    chk("R1 busErr", {127'b0, busErr}, '0);
    chk("R1 busRdata", {96'b0, busRdata}, '0);
    for (int b = 0; b < NB; b++) begin
      busRd(8'(12*b), rd);   chk("R1 data reg", {96'b0, rd}, '0);
      busRd(8'(12*b+4), rd); chk("R1 dir reg", {96'b0, rd}, '0);
    end

    // R2 R3 register writes and pin drive
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < NB; b++) begin
        mData[b] = pat(b, k);
        mDir[b]  = ~pat(b, k + 5);
        busWr(8'(12*b), mData[b]);
        busWr(8'(12*b+4), mDir[b]);
      end
      for (int b = 0; b < NB; b++) begin
        chk("R3 padOut slice", {96'b0, padOut[b*DW +: DW]}, {96'b0, mData[b]});
        chk("R3 padOe slice", {96'b0, padOe[b*DW +: DW]}, {96'b0, mDir[b]});
        busRd(8'(12*b), rd);   chk("R2 data readback", {96'b0, rd}, {96'b0, mData[b]});
        busRd(8'(12*b+4), rd); chk("R2 dir readback", {96'b0, rd}, {96'b0, mDir[b]});
      end
    end

    // R4 merged value under several pad patterns
    for (int k = 0; k < 5; k++) begin
      for (int b = 0; b < NB; b++) padIn[b*DW +: DW] = pat(b + 3, k * 11);
      repeat (3) @(negedge clk);
      for (int b = 0; b < NB; b++) begin
        busRd(8'('h50 + 4*b), rd);
        chk("R4 merged value", {96'b0, rd}, {96'b0, effOf(b)});
      end
    end

    // R5 writes to merged-value offsets ignored
    for (int b = 0; b < NB; b++) busWr(8'('h50 + 4*b), 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++) begin
      chk("R5 padOut unchanged", {96'b0, padOut[b*DW +: DW]}, {96'b0, mData[b]});
      chk("R5 padOe unchanged", {96'b0, padOe[b*DW +: DW]}, {96'b0, mDir[b]});
      busRd(8'('h50 + 4*b), rd);
      chk("R5 merged unchanged", {96'b0, rd}, {96'b0, effOf(b)});
    end

    // R6 two-flop delay on pad inputs (bank 0 all inputs)
    mDir[0] = '0;
    busWr(8'h04, '0);
    padIn[DW-1:0] = 32'h0F0F_1234;
    repeat (3) @(negedge clk);
    oldPad = padIn;
    padIn[DW-1:0] = 32'hF0F0_ABCD;
    busRd(8'h50, r1);
    busRd(8'h50, r2);
    busRd(8'h50, r3);
    chk("R6 first read old", {96'b0, r1}, {96'b0, oldPad[DW-1:0]});
    chk("R6 second read old", {96'b0, r2}, {96'b0, oldPad[DW-1:0]});
    chk("R6 third read new", {96'b0, r3}, {96'b0, 32'hF0F0_ABCD});

    // R7 identifier and acknowledge read zero, acknowledge forwarded
    busRd(8'h64, rd); chk("R7 id zero", {96'b0, rd}, '0);
    busRd(8'h4c, rd); chk("R7 ack reads zero", {96'b0, rd}, '0);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 8'h4c; busWdata = 32'h0000_00FF;
    #1;
    chk("R7 ack write forwarded", {94'b0, irqAccess, irqWrite, irqAddr, irqWdata},
        {94'b0, 1'b1, 1'b1, 8'h4c, 32'h0000_00FF});
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;

    // R8 interrupt window forwarding and read data
    for (int a = 'h30; a <= 'h48; a += 4) begin
      busSel = 1'b1; busWrite = 1'b0; busAddr = 8'(a);
      #1;
      chk("R8 irqAccess on read", {127'b0, irqAccess & ~irqWrite}, 128'd1);
      @(posedge clk); @(negedge clk);
      busSel = 1'b0;
      chk("R8 irq read data", {96'b0, busRdata}, {96'b0, 24'hC3C3C3, 8'(a)});
    end
    busAddr = 8'h50; busSel = 1'b1; #1;
    chk("R8 no forward outside window", {127'b0, irqAccess}, '0);
    @(posedge clk); @(negedge clk); busSel = 1'b0;

    // R9 no error yet; unmapped write has no effect
    chk("R9 no error on mapped", {127'b0, busErr}, '0);
    busWr(8'h08, 32'hDEAD_BEEF);
    busWr(8'h01, 32'hDEAD_BEEF);
    chk("R9 error set", {127'b0, busErr}, 128'd1);
    for (int b = 0; b < NB; b++) begin
      busRd(8'(12*b), rd);   chk("R9 data untouched", {96'b0, rd}, {96'b0, mData[b]});
      busRd(8'(12*b+4), rd); chk("R9 dir untouched", {96'b0, rd}, {96'b0, mDir[b]});
    end

    // R9 R10 full offset sweep including misaligned offsets
    for (int a = 0; a < 256; a++) begin
      if (a % 4 == 0 || a % 16 == 1 || a % 32 == 6) begin
        busRd(8'(a), rd);
        chk(isMapped(a) ? "R10 mapped read" : "R9 unmapped read zero",
            {96'b0, rd}, {96'b0, isMapped(a) ? expRead(a) : 32'h0});
      end
    end
    repeat (2) @(negedge clk);
    chk("R10 read data held", {96'b0, busRdata}, {96'b0, rd});
    chk("R9 error sticky", {127'b0, busErr}, 128'd1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule